// File: doc/BRIEF.md
# Serial Port Modem Line Control and Diagnostic Loopback

This block sits beside the transmitter and receiver of a serial port. It holds the modem control byte and reports the state of the four incoming handshake lines. Software writes the control byte through a small byte-wide register port, and the block drives the four active-low handshake outputs from it. The block synchronizes the incoming handshake lines, reports them active-high, and latches a change flag for each line. The change flags can raise a modem interrupt, which the auxiliary interrupt-gate control bit either lets through or holds off.

A diagnostic mode ties the serial path back on itself. The transmit shift-register output goes straight to the receiver input, and the line pin is parked at idle. The four control bits replace the handshake input pins, so software can exercise the status path and its interrupt without any cable attached. The control register is at offset 4 and the status register at offset 6. Every other offset reads as zero and ignores writes.

Top module: `modem_line_unit`

## Requirements
- R1: After reset the control register reads 00h. A write to offset 4 stores bits 4:0 (bit0 DTR, bit1 RTS, bit2 auxiliary output, bit3 interrupt gate, bit4 loopback), and bits 7:5 always read 0.
- R2: With loopback clear, each of DTR, RTS, auxiliary and gate drives its active-low pin (dtrN, rtsN, auxOutN, irqGateN) to the inverse of the bit.
- R3: The modem interrupt is never asserted while the interrupt-gate bit (control bit 3) is 0.
- R4: With loopback set, txPin, rtsN, dtrN, auxOutN and irqGateN are all held at 1.
- R5: With loopback clear, rxShiftIn follows rxPin and txPin follows txShiftOut. With loopback set, rxShiftIn follows txShiftOut, so a held-low break also passes through.
- R6: With loopback set, the handshake input pins have no effect. DTR appears as DSR, RTS as CTS, the auxiliary bit as RI and the gate bit as DCD, each active-high.
- R7: Reading offset 6 returns status bits 7:4 = DCD, RI, DSR, CTS (active-high). The inputs pass through two synchronizing flops, so a pin change before edge k is visible after edge k+1.
- R8: Status bits 3:0 are change flags for DCD, RI, DSR and CTS. Each sets one clock after its status bit changes. The RI flag sets only when RI goes from 1 to 0.
- R9: Change flags stay set until a read of offset 6 clears them. A change that coincides with the clearing read keeps its flag set.
- R10: The modem interrupt equals (any change flag set) AND msIntEn AND the interrupt-gate bit, in normal and loopback mode alike.
- R11: Reads of offsets other than 4 and 6 return 00h. Writes to them, and to offset 6, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register offset |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe (clears change flags at offset 6) |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, combinational on regAddr |
| txShiftOut | input | 1 | Transmit shift-register serial output |
| txPin | output | 1 | Serial line output pin |
| rxPin | input | 1 | Serial line input pin |
| rxShiftIn | output | 1 | Receive shift-register serial input |
| ctsN | input | 1 | Clear-to-send input, active low |
| dsrN | input | 1 | Data-set-ready input, active low |
| dcdN | input | 1 | Carrier-detect input, active low |
| riN | input | 1 | Ring-indicator input, active low |
| rtsN | output | 1 | Request-to-send output, active low |
| dtrN | output | 1 | Data-terminal-ready output, active low |
| auxOutN | output | 1 | Auxiliary output, active low |
| irqGateN | output | 1 | Interrupt-gate output, active low |
| msIntEn | input | 1 | Modem-status interrupt enable |
| modemIrq | output | 1 | Modem-status interrupt |

## Verification
The clearing read of the status register and a fresh line change can land on the same clock edge. In that case the flag must survive the read. The bench provokes this by holding the status read strobe high for several cycles while handshake pins toggle. It also runs a long random phase with reads at a high rate, so the new change and the clear coincide on many edges. A behavioural model compares the full read value and the interrupt on every clock, so a lost or stale flag shows up in the cycle it occurs.

// File: rtl/mlu_pkg.sv
`timescale 1ns/1ps
package mlu_pkg;
  localparam int DATA_W  = 8;
  localparam int CTRL_W  = 5;
  localparam int LINES   = 4;
  // control bit positions
  localparam int CB_DTR  = 0;
  localparam int CB_RTS  = 1;
  localparam int CB_AUX  = 2;
  localparam int CB_GATE = 3;
  localparam int CB_LOOP = 4;
  // status line positions (upper nibble order)
  localparam int LN_CTS  = 0;
  localparam int LN_DSR  = 1;
  localparam int LN_RI   = 2;
  localparam int LN_DCD  = 3;

  typedef struct packed {
    logic ctrlWr;
    logic statusRd;
  } mlu_strobe_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2
  } mlu_rdsel_t;
endpackage

// File: rtl/mlu_ctrl.sv
`timescale 1ns/1ps
module mlu_ctrl
  import mlu_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int CTRL_OFS = 4,
  parameter int STAT_OFS = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWr,
  input  logic                regRd,
  input  logic [CTRL_W-1:0]   ctrlVal,
  input  logic [DATA_W-1:0]   statVal,
  output mlu_strobe_t         strobe,
  output logic [DATA_W-1:0]   regRdata
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

  mlu_rdsel_t rdSel;

  always_comb begin
    if (regAddr == CTRL_A)      rdSel = SEL_CTRL;
    else if (regAddr == STAT_A) rdSel = SEL_STAT;
    else                        rdSel = SEL_NONE;
  end

  always_comb begin
    strobe.ctrlWr   = regWr && (rdSel == SEL_CTRL);
    strobe.statusRd = regRd && (rdSel == SEL_STAT);
  end

  always_comb begin
    unique case (rdSel)
      SEL_CTRL: regRdata = {{(DATA_W-CTRL_W){1'b0}}, ctrlVal};
      SEL_STAT: regRdata = statVal;
      default:  regRdata = '0;
    endcase
  end

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == CTRL_A) |-> (regRdata[DATA_W-1:CTRL_W] == '0)); // R1

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((regAddr != CTRL_A) && (regAddr != STAT_A)) |-> (regRdata == '0)); // R11
endmodule

// File: rtl/mlu_datapath.sv
`timescale 1ns/1ps
module mlu_datapath
  import mlu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  mlu_strobe_t        strobe,
  input  logic [CTRL_W-1:0]  wdata,
  input  logic               txShiftOut,
  input  logic               rxPin,
  input  logic [LINES-1:0]   linePinsN,
  input  logic               msIntEn,
  output logic [CTRL_W-1:0]  ctrlVal,
  output logic [DATA_W-1:0]  statVal,
  output logic               txPin,
  output logic               rxShiftIn,
  output logic               dtrN,
  output logic               rtsN,
  output logic               auxOutN,
  output logic               irqGateN,
  output logic               modemIrq
);
  logic [CTRL_W-1:0]                  ctrlQ;
  logic [SYNC_STAGES-1:0][LINES-1:0]  syncStage;
  logic [LINES-1:0]                   rawLine;
  logic [LINES-1:0]                   lineNow;
  logic [LINES-1:0]                   linePrev;
  logic [LINES-1:0]                   lineHit;
  logic [LINES-1:0]                   deltaQ;
  logic                               loopOn;

  assign loopOn = ctrlQ[CB_LOOP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ctrlQ <= '0;
    else if (strobe.ctrlWr) ctrlQ <= wdata;
  end

  // line source select: control bits in loopback, inverted pins otherwise
  always_comb begin
    if (loopOn) begin
      rawLine[LN_CTS] = ctrlQ[CB_RTS];
      rawLine[LN_DSR] = ctrlQ[CB_DTR];
      rawLine[LN_RI]  = ctrlQ[CB_AUX];
      rawLine[LN_DCD] = ctrlQ[CB_GATE];
    end else begin
      rawLine = ~linePinsN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncStage <= '0;
      linePrev  <= '0;
    end else begin
      syncStage[0] <= rawLine;
      for (int s = 1; s < SYNC_STAGES; s++) syncStage[s] <= syncStage[s-1];
      linePrev <= lineNow;
    end
  end

  assign lineNow = syncStage[SYNC_STAGES-1];

  for (genvar b = 0; b < LINES; b++) begin : g_hit
    if (b == LN_RI) begin : g_trail
      assign lineHit[b] = linePrev[b] & ~lineNow[b];
    end else begin : g_any
      assign lineHit[b] = linePrev[b] ^ lineNow[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) deltaQ <= '0;
    else       deltaQ <= (strobe.statusRd ? '0 : deltaQ) | lineHit;
  end

  assign ctrlVal   = ctrlQ;
  assign statVal   = {lineNow, deltaQ};
  assign txPin     = loopOn ? 1'b1 : txShiftOut;
  assign rxShiftIn = loopOn ? txShiftOut : rxPin;
  assign dtrN      = loopOn | ~ctrlQ[CB_DTR];
  assign rtsN      = loopOn | ~ctrlQ[CB_RTS];
  assign auxOutN   = loopOn | ~ctrlQ[CB_AUX];
  assign irqGateN  = loopOn | ~ctrlQ[CB_GATE];
  assign modemIrq  = (|deltaQ) & msIntEn & ctrlQ[CB_GATE];

  AST_CTRL_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ctrlWr |=> (ctrlQ == $past(wdata))); // R1

  AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.statusRd |=> ((deltaQ & $past(deltaQ)) == $past(deltaQ))); // R9

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.statusRd && (linePrev == lineNow)) |=> (deltaQ == '0)); // R9
endmodule

// File: rtl/modem_line_unit.sv
`timescale 1ns/1ps
module modem_line_unit
  import mlu_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int CTRL_OFS    = 4,
  parameter int STAT_OFS    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              txShiftOut,
  output logic              txPin,
  input  logic              rxPin,
  output logic              rxShiftIn,
  input  logic              ctsN,
  input  logic              dsrN,
  input  logic              dcdN,
  input  logic              riN,
  output logic              rtsN,
  output logic              dtrN,
  output logic              auxOutN,
  output logic              irqGateN,
  input  logic              msIntEn,
  output logic              modemIrq
);
  mlu_strobe_t       strobe;
  logic [CTRL_W-1:0] ctrlVal;
  logic [DATA_W-1:0] statVal;
  logic [LINES-1:0]  linePinsN;
  logic              unusedWdataHi;

  assign unusedWdataHi = ^regWdata[DATA_W-1:CTRL_W];

  always_comb begin
    linePinsN[LN_CTS] = ctsN;
    linePinsN[LN_DSR] = dsrN;
    linePinsN[LN_RI]  = riN;
    linePinsN[LN_DCD] = dcdN;
  end

  mlu_ctrl #(
    .ADDR_W   (ADDR_W),
    .CTRL_OFS (CTRL_OFS),
    .STAT_OFS (STAT_OFS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWr    (regWr),
    .regRd    (regRd),
    .ctrlVal  (ctrlVal),
    .statVal  (statVal),
    .strobe   (strobe),
    .regRdata (regRdata)
  );

  mlu_datapath #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wdata      (regWdata[CTRL_W-1:0]),
    .txShiftOut (txShiftOut),
    .rxPin      (rxPin),
    .linePinsN  (linePinsN),
    .msIntEn    (msIntEn),
    .ctrlVal    (ctrlVal),
    .statVal    (statVal),
    .txPin      (txPin),
    .rxShiftIn  (rxShiftIn),
    .dtrN       (dtrN),
    .rtsN       (rtsN),
    .auxOutN    (auxOutN),
    .irqGateN   (irqGateN),
    .modemIrq   (modemIrq)
  );

  AST_IRQ_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (modemIrq && !ctrlVal[CB_LOOP]) |-> !irqGateN); // R3

  AST_LOOP_PINS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ctrlVal[CB_LOOP] |-> (txPin && rtsN && dtrN && auxOutN && irqGateN)); // R4
endmodule

// File: tb/modem_line_unit_test.sv
`timescale 1ns/1ps
module modem_line_unit_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] regAddr;
  logic       regWr, regRd;
  logic [7:0] regWdata;
  logic [7:0] regRdata;
  logic       txShiftOut, txPin, rxPin, rxShiftIn;
  logic       ctsN, dsrN, dcdN, riN;
  logic       rtsN, dtrN, auxOutN, irqGateN;
  logic       msIntEn, modemIrq;

  int vectors = 0;
  int miscompares = 0;
  bit modelLive = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  modem_line_unit uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .txShiftOut(txShiftOut),
    .txPin(txPin), .rxPin(rxPin), .rxShiftIn(rxShiftIn), .ctsN(ctsN),
    .dsrN(dsrN), .dcdN(dcdN), .riN(riN), .rtsN(rtsN), .dtrN(dtrN),
    .auxOutN(auxOutN), .irqGateN(irqGateN), .msIntEn(msIntEn),
    .modemIrq(modemIrq)
  );

  // behavioural reference: status nibble {DCD,RI,DSR,CTS}
  logic [7:0] mCtrl;
  logic [3:0] mPipe[$];
  logic [3:0] mPrev, mDelta, mSt, mRaw, mHit;

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 8'h00; mPipe = {4'h0, 4'h0}; mPrev = 4'h0; mDelta = 4'h0;
      modelLive = 1;
    end else begin
      mSt = mPipe[0];
      mHit = mSt ^ mPrev;
      mHit[2] = mPrev[2] & ~mSt[2];           // R8 ring flag on 1->0 only
      mDelta = ((regRd && regAddr == 3'd6) ? 4'h0 : mDelta) | mHit;  // R9
      mPrev = mSt;
      if (mCtrl[4]) mRaw = {mCtrl[3], mCtrl[2], mCtrl[0], mCtrl[1]}; // R6
      else          mRaw = ~{dcdN, riN, dsrN, ctsN};
      mPipe.push_back(mRaw);
      void'(mPipe.pop_front());
      if (regWr && regAddr == 3'd4) mCtrl = regWdata & 8'h1F;
    end
  end

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (modelLive && !done) begin
      logic lp;
      logic [7:0] expRd;
      lp = mCtrl[4];
      if (regAddr == 3'd4)      begin expRd = mCtrl; check("R1", "control read", regRdata, expRd); end
      else if (regAddr == 3'd6) begin expRd = {mPipe[0], mDelta}; check("R9", "status read", regRdata, expRd); end
      else                      check("R11", "unmapped read", regRdata, 8'h00);
      check(lp ? "R4" : "R2", "control pins {gate,aux,rts,dtr}",
            {4'h0, irqGateN, auxOutN, rtsN, dtrN},
            lp ? 8'h0F : {4'h0, ~mCtrl[3], ~mCtrl[2], ~mCtrl[1], ~mCtrl[0]});
      check("R5", "serial {txPin,rxShiftIn}", {6'h0, txPin, rxShiftIn},
            lp ? {6'h0, 1'b1, txShiftOut} : {6'h0, txShiftOut, rxPin});
      check("R3/R10", "modem interrupt", {7'h0, modemIrq},
            {7'h0, (|mDelta) & msIntEn & mCtrl[3]});
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(logic [2:0] a, logic [7:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask
  task automatic rd(logic [2:0] a);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    rstN = 0; regAddr = 3'd4; regWr = 0; regRd = 0; regWdata = 8'h00;
    txShiftOut = 1; rxPin = 1; ctsN = 1; dsrN = 1; dcdN = 1; riN = 1; msIntEn = 0;
    idle(3);
    rstN = 1;
    // R1 reset value and reserved bits
    idle(2); rd(3'd4);
    wr(3'd4, 8'hE7); rd(3'd4);
    // R2 pin polarity
    wr(3'd4, 8'h05); idle(2); wr(3'd4, 8'h0A); idle(2);
    // R7 R8 status layout, sync latency and flags
    msIntEn = 1;
    ctsN = 0; idle(4); rd(3'd6);
    dsrN = 0; idle(4); rd(3'd6);
    riN = 0;  idle(4); rd(3'd6);   // rising RI: no flag
    riN = 1;  idle(4); rd(3'd6);   // trailing RI: flag
    dcdN = 0; idle(4); rd(3'd6);
    // R3 gate bit off blocks interrupt, then on
    wr(3'd4, 8'h00); ctsN = 1; idle(4);
    wr(3'd4, 8'h08); idle(2);
    msIntEn = 0; idle(2); msIntEn = 1; rd(3'd6);
    // R9 clearing read held while lines change in the same cycle
    regAddr = 3'd6; regRd = 1;
    dsrN = 1; idle(1); dcdN = 1; idle(2); ctsN = 0; idle(3);
    regRd = 0; idle(2); rd(3'd6);
    // R5 normal serial path
    txShiftOut = 0; idle(1); rxPin = 0; idle(1); txShiftOut = 1; rxPin = 1; idle(1);
    // R6 loopback: pins ignored, control bits become lines
    wr(3'd4, 8'h10); idle(4); rd(3'd6);
    txShiftOut = 0; idle(3); rxPin = 0; idle(1); txShiftOut = 1; rxPin = 1;
    ctsN = 1; dsrN = 0; riN = 0; dcdN = 0; idle(4);
    wr(3'd4, 8'h11); idle(4); rd(3'd6);
    wr(3'd4, 8'h1F); idle(4); rd(3'd6);
    wr(3'd4, 8'h1A); idle(4); rd(3'd6);
    // leaving loopback
    wr(3'd4, 8'h08); idle(4); rd(3'd6); idle(2);
    // R11 unmapped offsets and status writes
    wr(3'd5, 8'hFF); wr(3'd0, 8'h1F); wr(3'd6, 8'h1F);
    rd(3'd5); rd(3'd7); rd(3'd4);
    // mixed random traffic
    for (int i = 0; i < 1500; i++) begin
      case ($urandom % 4)
        0: regAddr = 3'd4;
        1: regAddr = 3'd5;
        default: regAddr = 3'd6;
      endcase
      regWr = (($urandom % 5) == 0);
      regRd = (($urandom % 3) == 0);
      regWdata = 8'($urandom);
      if (($urandom % 3) == 0) {ctsN, dsrN, dcdN, riN} = 4'($urandom);
      txShiftOut = 1'($urandom);
      rxPin = 1'($urandom);
      if (($urandom % 8) == 0) msIntEn = ~msIntEn;
      @(negedge clk);
    end
    regWr = 0; regRd = 0;
    idle(3);
    finishRun();
  end
endmodule